// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion from the system clock. A start request launches a sample phase, during which the analog input is tracked, followed by one conversion step for each bit of the result. The block drives a level that is high for the whole sample phase, a one-cycle strobe for each conversion step, a one-cycle done pulse at the end, and a busy level covering the whole conversion. The comparator, the result register and the channel multiplexer sit outside and follow these outputs.

All timing derives from a basic conversion tick. A free prescaler counter produces this tick as a single-cycle enable; no derived clock is created. Two fields of a 16-bit control word set the timing. One field selects the prescale divisor, whose code order is deliberately not monotonic. The other field selects the sample length as a count of basic ticks.

Both fields are captured when a start is accepted. Rewriting the control word during a conversion therefore has no effect until the next start. No data stream passes through the block, so every pin is a plain control or status level and there is no valid/ready handshake.

Top module: `adc_seq_timer`

## Requirements
- R1: The divisor code is taken from control bits 15:14 and the sample code from bits 13:12, sampled on the clock edge where a start is accepted; the other control bits have no effect.
- R2: Divisor code 2'b00 gives one basic tick every 4 clocks, 2'b01 every 2, 2'b10 every 16, and 2'b11 every 8.
- R3: Sample code 2'b00, 2'b01, 2'b10 and 2'b11 give sample phases of 8, 16, 32 and 64 basic periods; sample_en is high for exactly that many basic periods times the divisor, starting the cycle after acceptance.
- R4: After the sample phase, step_stb pulses exactly RES_BITS times (10 by default), once in the last clock of each basic period.
- R5: done is high for exactly one cycle, the cycle after the last step strobe; the block is idle in the next cycle.
- R6: busy is high from the cycle after a start is accepted through the done cycle inclusive, and low otherwise.
- R7: A start seen while busy is high, including in the done cycle, is ignored; a start held high is accepted again in the first idle cycle.
- R8: Changes to the control word while busy is high do not alter the timing of the conversion in progress.
- R9: A synchronous active-high reset, taken at any time, makes every output low in the following cycle and restarts the prescaler and phase counters.
- R10: sample_en and step_stb are never high together, and all outputs except busy are low while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, accepted when idle |
| ctrl_word | input | 16 | Control word: divisor code in 15:14, sample code in 13:12 |
| busy | output | 1 | Conversion in progress |
| sample_en | output | 1 | Sample phase active |
| step_stb | output | 1 | One-cycle strobe per conversion step |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with the default resolution of 10. A step count that is not a power of two checks that the step counter's terminal value is decoded exactly, rather than by a wrap of the counter. All sixteen pairs of divisor and sample codes are run, including the longest case of 1024 sample clocks at divide-by-16. This tests both the scrambled divisor order and the exact terminal counts. Start pulses and control rewrites are injected during busy phases and in the done cycle, and a reset is applied in the middle of a conversion. This checks capture, the ignore rule and recovery against a behavioural model that tracks time since acceptance.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_STEP   = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;

  localparam int MAX_DIV  = 16;
  localparam int MAX_SAMP = 64;
  localparam int DIV_W    = $clog2(MAX_DIV);
  localparam int SAMP_W   = $clog2(MAX_SAMP);

  // divisor minus one for a prescale code (order is 4, 2, 16, 8)
  function automatic logic [DIV_W-1:0] div_last(input logic [1:0] code);
    case (code)
      2'b00:   div_last = DIV_W'(3);
      2'b01:   div_last = DIV_W'(1);
      2'b10:   div_last = DIV_W'(15);
      default: div_last = DIV_W'(7);
    endcase
  endfunction

  // sample length in basic periods minus one (8 << code)
  function automatic logic [SAMP_W-1:0] samp_last(input logic [1:0] code);
    logic [SAMP_W:0] n;
    n = (SAMP_W+1)'(8) << code;
    samp_last = SAMP_W'(n - 1'b1);
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic [CTRL_W-1:0]   ctrl_word,
  output logic [DIV_W-1:0]    div_m1,
  output logic [SAMP_W-1:0]   samp_m1
);
  localparam int DC_HI = CTRL_W - 1;
  localparam int SC_HI = CTRL_W - 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_m1  <= '0;
      samp_m1 <= '0;
    end else if (accept) begin
      div_m1  <= div_last(ctrl_word[DC_HI -: 2]);
      samp_m1 <= samp_last(ctrl_word[SC_HI -: 2]);
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(div_m1) && $stable(samp_m1)));
endmodule

// File: rtl/adc_seq_presc.sv
module adc_seq_presc
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_m1);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R2: smallest divisor is 2, so ticks are never adjacent
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  input  logic [SAMP_W-1:0] samp_m1,
  output logic              accept,
  output logic              run,
  output logic              busy,
  output logic              sample_en,
  output logic              step_stb,
  output logic              done
);
  localparam int STEP_W = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RES_BITS - 1);

  phase_t            phase;
  logic [SAMP_W-1:0] s_cnt;
  logic [STEP_W-1:0] k_cnt;

  assign accept    = start && (phase == PH_IDLE) && !rst;
  assign run       = (phase == PH_SAMPLE) || (phase == PH_STEP);
  assign busy      = (phase != PH_IDLE);
  assign sample_en = (phase == PH_SAMPLE);
  assign step_stb  = (phase == PH_STEP) && tick;
  assign done      = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      s_cnt <= '0;
      k_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) phase <= PH_SAMPLE;
        PH_SAMPLE: if (tick) begin
          if (s_cnt == samp_m1) begin
            s_cnt <= '0;
            phase <= PH_STEP;
          end else begin
            s_cnt <= s_cnt + 1'b1;
          end
        end
        PH_STEP: if (tick) begin
          if (k_cnt == STEP_LAST) begin
            k_cnt <= '0;
            phase <= PH_DONE;
          end else begin
            k_cnt <= k_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    k_cnt <= STEP_LAST);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));
  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_en && step_stb));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy);
  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !sample_en && !step_stb && !done));
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int CTRL_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              busy,
  output logic              sample_en,
  output logic              step_stb,
  output logic              done
);
  logic              accept;
  logic              run;
  logic              tick;
  logic [DIV_W-1:0]  div_m1;
  logic [SAMP_W-1:0] samp_m1;

  adc_seq_cfg #(.CTRL_W(CTRL_W)) u_cfg (
    .clk(clk), .rst(rst), .accept(accept), .ctrl_word(ctrl_word),
    .div_m1(div_m1), .samp_m1(samp_m1)
  );

  adc_seq_presc u_presc (
    .clk(clk), .rst(rst), .run(run), .div_m1(div_m1), .tick(tick)
  );

  adc_seq_phase #(.RES_BITS(RES_BITS)) u_phase (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .samp_m1(samp_m1),
    .accept(accept), .run(run), .busy(busy), .sample_en(sample_en),
    .step_stb(step_stb), .done(done)
  );

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && sample_en));
endmodule

// File: tb/sim_adc_seq_timer.sv
module sim_adc_seq_timer;
  localparam int RES = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] ctrl_word = 16'h0;
  logic        busy, sample_en, step_stb, done;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit finished = 0;

  // behavioural model: time since acceptance, -1 when idle
  int t = -1;
  int m_div = 4;
  int m_samp = 8;

  always #2 clk = ~clk;

  adc_seq_timer #(.RES_BITS(RES)) u0 (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
    .busy(busy), .sample_en(sample_en), .step_stb(step_stb), .done(done)
  );

  function automatic int div_of(input logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 16;
      default: return 8;
    endcase
  endfunction

  // R1 R2 R3: fields captured only at acceptance; R7 R8: ignored while busy
  always @(posedge clk) begin
    if (rst) t = -1;
    else if (t < 0) begin
      if (start) begin
        t = 0;
        m_div  = div_of(ctrl_word[15:14]);
        m_samp = 8 << ctrl_word[13:12];
      end
    end else if (t == m_samp*m_div + RES*m_div) t = -1;
    else t = t + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int sd, tot;
    logic e_busy, e_samp, e_step, e_done;
    if (!finished) begin
      cycles++;
      sd  = m_samp * m_div;
      tot = sd + RES * m_div;
      e_busy = (t >= 0);
      e_samp = (t >= 0) && (t < sd);
      e_step = (t >= sd) && (t < tot) && (((t - sd) % m_div) == m_div - 1);
      e_done = (t == tot);
      chk("R6 busy", busy, e_busy);
      chk("R3 sample_en", sample_en, e_samp);
      chk("R4 step_stb", step_stb, e_step);
      chk("R5 done", done, e_done);
      chk("R10 exclusive", sample_en && step_stb, 1'b0);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one conversion, optionally disturbing start and control while busy
  task automatic convert(input logic [1:0] dc, input logic [1:0] sc, input bit disturb);
    @(negedge clk);
    ctrl_word = {dc, sc, 12'($urandom)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (t >= 0) begin
      if (disturb) begin
        start = 1'($urandom);
        ctrl_word = 16'($urandom);
      end
      @(negedge clk);
    end
    start = 1'b0;
    idle_cycles(3);
  endtask

  initial begin
    idle_cycles(3);
    rst = 1'b0;
    idle_cycles(2);
    // R1 R2 R3 R4: every divisor and sample code pair
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++)
        convert(2'(d), 2'(s), (d + s) % 2 == 1);
    // R7: start held high is re-accepted right after done
    ctrl_word = 16'b01_00_0000_0000_0000;
    start = 1'b1;
    idle_cycles(400);
    start = 1'b0;
    idle_cycles(60);
    // R8: control rewrites throughout a conversion
    convert(2'b11, 2'b10, 1'b1);
    // R9: reset in the middle of a conversion
    ctrl_word = 16'b10_01_0000_0000_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idle_cycles(100);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 busy after reset", busy, 1'b0);
    chk("R9 sample_en after reset", sample_en, 1'b0);
    rst = 1'b0;
    idle_cycles(3);
    convert(2'b01, 2'b00, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule